// File: doc/BRIEF.md
# Bus-Controlled Eight-Pin Port Expander

This block gives a host eight general-purpose pins that it controls over a two-wire serial bus (I2C or SMBus). The block acts as a bus target. Its seven-bit address has five fixed high bits, `11100`. The two low bits come from a strap input, so four copies can share one bus.

The first byte after the address in a write transaction is a command byte. It loads a pointer that selects one of four registers:

| Pointer | Register | Access |
|---|---|---|
| 0 | Input sample | read-only |
| 1 | Drive value | read/write |
| 2 | Inversion mask | read/write |
| 3 | Direction | read/write |

A direction bit of 1 makes its pin an input, with the output driver off. A direction bit of 0 drives the pin from the drive-value register. Read transactions return the pointed register until a later write loads a new command byte.

The block keeps a snapshot of the raw pin levels. The snapshot is taken each time the input register is loaded for a read. An active-low, open-drain attention flag goes low while any input-configured pin differs from that snapshot. The bus lines and the pins are sampled with the block clock. All state returns to its defaults on the asynchronous active-low reset.

Top module: `gpio_expander_i2c`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal `11100` followed by `addr_strap[1]` and `addr_strap[0]`. Any other address gets no acknowledge, and the bus is left alone until the next START.
- R2: A command byte of 0 to 3 is acknowledged and loads the pointer. A command byte above 3 is not acknowledged and leaves the pointer unchanged.
- R3: A read returns the pointed register for every byte the master acknowledges. Later read transactions keep returning that register until a new command byte is written.
- R4: The input register reads as the synchronised pin levels XOR the inversion mask.
- R5: For each pin, `pin_oe` is the inverse of its direction bit. `pin_out` carries the drive-value bit on output pins and is 0 on input pins.
- R6: A read of the drive-value register returns the stored value, even for bits whose pins are inputs.
- R7: After reset: drive value FFh, inversion mask 00h, direction FFh, pointer 0, `int_low` low, `sda_oe` low.
- R8: `int_low` goes high when an input-configured pin differs from the snapshot. A change on an output-configured pin does not raise it.
- R9: `int_low` returns low when a read of the input register takes a new snapshot. It also returns low when the pins go back to the snapshot levels.
- R10: A data byte written with the pointer at 0 is acknowledged and changes nothing.
- R11: Several data bytes in one write all go to the same register, so the last byte written is kept.
- R12: Asserting `rst_n` in the middle of a transaction aborts it and restores the reset state of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, used to sample the bus lines and the pins |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| addr_strap | input | 2 | Low two bits of the target address |
| pin_in | input | 8 | Pin levels |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin drive value |
| int_low | output | 1 | 1 pulls the open-drain attention line low |

## Verification
The case that is hardest to reach from the ports is the attention flag clearing through a read, because it depends on when the snapshot was last taken.

To reach it, the bench first makes one input pin differ from the snapshot. It then toggles an output-configured pin and checks that the flag does not move. It restores the input pin to see the flag drop, and moves the pin again to raise it. Finally, it clears the flag with a read of the input register that follows an earlier pointer write.

The same sequence also shows the pointer persisting across transactions. Aborting reset is exercised with a data byte cut off after four bits.

// File: rtl/gpio_expander_i2c.sv
module gpio_expander_i2c #(
  parameter logic [4:0] ADDR_HI = 5'b11100,
  parameter int         PRIME   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [1:0] addr_strap,
  input  logic [7:0] pin_in,
  output logic [7:0] pin_oe,
  output logic [7:0] pin_out,
  output logic       int_low
);
  localparam int PW = $clog2(PRIME + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_WR, S_RD} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  logic [7:0] pin_sy, pin_s;
  logic [PW-1:0] prime;
  st_t        st;
  logic [3:0] cnt;
  logic [7:0] sr, tx;
  logic       ack_ph, rw, mack, int_q;
  logic [1:0] ptr;
  logic [7:0] outp, pol, cfg, snap, rd_val;

  wire scl    = scl_sy[1];
  wire sda    = sda_sy[1];
  wire s_rise = scl & ~scl_q;
  wire s_fall = ~scl & scl_q;
  wire start  = scl & scl_q & sda_q & ~sda;
  wire stop   = scl & scl_q & ~sda_q & sda;
  wire primed = (prime == PW'(PRIME));

  always_comb begin
    case (ptr)
      2'd0:    rd_val = pin_s ^ pol;
      2'd1:    rd_val = outp;
      2'd2:    rd_val = pol;
      default: rd_val = cfg;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
      pin_sy <= '0; pin_s <= '0; prime <= '0; int_q <= 1'b0;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl;
      sda_q  <= sda;
      pin_sy <= pin_in;
      pin_s  <= pin_sy;
      if (!primed) prime <= prime + 1'b1;
      int_q  <= primed && |((pin_s ^ snap) & cfg);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sr <= '0; tx <= '0;
      ack_ph <= 1'b0; rw <= 1'b0; mack <= 1'b0; ptr <= '0;
      outp <= 8'hFF; pol <= 8'h00; cfg <= 8'hFF; snap <= '0;
    end else begin
      if (!primed) snap <= pin_s;
      if (start) begin
        st <= S_ADDR; cnt <= '0; ack_ph <= 1'b0; mack <= 1'b0;
      end else if (stop) begin
        st <= S_IDLE; ack_ph <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_CMD, S_WR: begin
            if (s_rise && !ack_ph && cnt < 4'd8) begin
              sr  <= {sr[6:0], sda};
              cnt <= cnt + 4'd1;
            end else if (s_fall && ack_ph) begin
              ack_ph <= 1'b0;
              cnt    <= '0;
              if (st == S_ADDR) begin
                if (rw) begin
                  st <= S_RD; tx <= rd_val; mack <= 1'b0;
                  if (ptr == 2'd0) snap <= pin_s;
                end else st <= S_CMD;
              end else st <= S_WR;
            end else if (s_fall && cnt == 4'd8) begin
              case (st)
                S_ADDR:
                  if (sr[7:1] == {ADDR_HI, addr_strap}) begin
                    ack_ph <= 1'b1; rw <= sr[0];
                  end else st <= S_IDLE;
                S_CMD:
                  if (sr < 8'd4) begin
                    ack_ph <= 1'b1; ptr <= sr[1:0];
                  end else st <= S_IDLE;
                default: begin
                  ack_ph <= 1'b1;
                  case (ptr)
                    2'd1: outp <= sr;
                    2'd2: pol  <= sr;
                    2'd3: cfg  <= sr;
                    default: ;
                  endcase
                end
              endcase
            end
          end
          S_RD: begin
            if (s_fall && cnt < 4'd8) begin
              tx  <= {tx[6:0], 1'b0};
              cnt <= cnt + 4'd1;
            end else if (s_rise && cnt == 4'd8) begin
              if (sda) st <= S_IDLE;
              else     mack <= 1'b1;
            end else if (s_fall && cnt == 4'd8 && mack) begin
              tx <= rd_val; cnt <= '0; mack <= 1'b0;
              if (ptr == 2'd0) snap <= pin_s;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe  = ack_ph | (st == S_RD && cnt < 4'd8 && !tx[7]);
  assign pin_oe  = ~cfg;
  assign pin_out = outp & ~cfg;
  assign int_low = int_q;

  a_r1_idle_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);
  a_r2_ptr_only_by_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptr) |-> $past(st) == S_CMD);
  a_r10_wr_data_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR && !ack_ph) |-> !sda_oe);
  a_r11_regs_only_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(outp) || !$stable(pol) || !$stable(cfg)) |-> $past(st) == S_WR);
  a_r9_int_quiet_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && ((pin_s ^ snap) & cfg) == 8'h00) |=> !int_low);
  a_r5_input_pins_undriven: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == 8'h00);
endmodule

// File: tb/gpio_expander_i2c_tb_top.sv
module gpio_expander_i2c_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_mlow = 1'b0;
  logic [1:0] strap = 2'b10;
  logic [7:0] pin_in = 8'h00;
  logic sda_oe, int_low;
  logic [7:0] pin_oe, pin_out;
  logic sda_line;
  assign sda_line = ~(sda_mlow | sda_oe);

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [7:0] rx_last;
  event rd_ev;
  localparam logic [6:0] ADR = 7'b1110010;

  always #5 clk = ~clk;

  gpio_expander_i2c dut_i (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .addr_strap(strap), .pin_in(pin_in), .pin_oe(pin_oe),
    .pin_out(pin_out), .int_low(int_low));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(rd_ev);
      if (exp_q.size() == 0) chk("scoreboard_empty", 1, 0);
      else chk(tag_q.pop_front(), rx_last, exp_q.pop_front());
    end
  end

  task automatic hp(); repeat (10) @(negedge clk); endtask

  task automatic i_start();
    sda_mlow = 0; scl_m = 1; hp(); sda_mlow = 1; hp(); scl_m = 0; repeat (2) @(negedge clk);
  endtask

  task automatic i_stop();
    sda_mlow = 1; hp(); scl_m = 1; hp(); sda_mlow = 0; hp();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_mlow = !b[i]; hp(); scl_m = 1; hp(); scl_m = 0; repeat (2) @(negedge clk);
    end
    sda_mlow = 0; hp(); scl_m = 1; repeat (5) @(negedge clk);
    ack = !sda_line; repeat (5) @(negedge clk); scl_m = 0; repeat (2) @(negedge clk);
  endtask

  task automatic recv_byte(input bit last);
    logic [7:0] b = '0;
    sda_mlow = 0;
    for (int i = 0; i < 8; i++) begin
      hp(); scl_m = 1; repeat (5) @(negedge clk);
      b = {b[6:0], sda_line}; repeat (5) @(negedge clk);
      scl_m = 0; repeat (2) @(negedge clk);
    end
    rx_last = b; ->rd_ev;
    sda_mlow = !last; hp(); scl_m = 1; hp(); scl_m = 0; repeat (2) @(negedge clk);
    sda_mlow = 0;
  endtask

  task automatic wr(input string tag, input logic [7:0] cmd, input int n,
                    input logic [7:0] d0, input logic [7:0] d1);
    logic a;
    i_start();
    send_byte({ADR, 1'b0}, a); chk({tag, " addr ack"}, a, 1);
    send_byte(cmd, a); chk({tag, " cmd ack"}, a, 1);
    if (n > 0) begin send_byte(d0, a); chk({tag, " data ack"}, a, 1); end
    if (n > 1) begin send_byte(d1, a); chk({tag, " data2 ack"}, a, 1); end
    i_stop();
  endtask

  task automatic rd(input string tag, input int n, input logic [7:0] e);
    logic a;
    i_start();
    send_byte({ADR, 1'b1}, a); chk({tag, " raddr ack"}, a, 1);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(e); tag_q.push_back(tag);
      recv_byte(i == n - 1);
    end
    i_stop();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog timeout");
    finish_run();
  end

  initial begin
    logic a;
    repeat (5) @(negedge clk); rst_n = 1; repeat (10) @(negedge clk);
    chk("R7 pin_oe reset", pin_oe, 8'h00);
    chk("R7 pin_out reset", pin_out, 8'h00);
    chk("R7 int reset", int_low, 0);
    chk("R7 sda released", sda_oe, 0);
    rd("R7 ptr default input", 1, 8'h00);
    wr("R7", 8'h01, 0, 0, 0); rd("R7 out default", 1, 8'hFF);
    wr("R7", 8'h02, 0, 0, 0); rd("R7 pol default", 1, 8'h00);
    wr("R7", 8'h03, 0, 0, 0); rd("R7 cfg default", 1, 8'hFF);

    i_start(); send_byte({7'b1110001, 1'b0}, a); i_stop();
    chk("R1 wrong strap nack", a, 0);
    i_start(); send_byte({7'b0100010, 1'b1}, a); i_stop();
    chk("R1 wrong prefix nack", a, 0);
    strap = 2'b01;
    i_start(); send_byte({7'b1110001, 1'b0}, a); i_stop();
    chk("R1 new strap ack", a, 1);
    strap = 2'b10;

    i_start(); send_byte({ADR, 1'b0}, a); send_byte(8'h04, a); i_stop();
    chk("R2 cmd 4 nack", a, 0);
    rd("R2 ptr kept after bad cmd", 1, 8'hFF);

    wr("R5 cfg", 8'h03, 1, 8'h0F, 0);
    wr("R5 out", 8'h01, 1, 8'hA5, 0);
    repeat (4) @(negedge clk);
    chk("R5 pin_oe", pin_oe, 8'hF0);
    chk("R5 pin_out", pin_out, 8'hA0);
    rd("R6 out readback", 1, 8'hA5);

    pin_in = 8'h3C;
    wr("R4 pol", 8'h02, 1, 8'h0F, 0);
    wr("R4 ptr", 8'h00, 0, 0, 0);
    rd("R4 input xor", 2, 8'h33);
    rd("R3 pointer persists", 1, 8'h33);
    repeat (6) @(negedge clk);
    chk("R9 int clear after read", int_low, 0);

    pin_in = 8'hBC; repeat (6) @(negedge clk);
    chk("R8 output pin change no int", int_low, 0);
    pin_in = 8'hBD; repeat (6) @(negedge clk);
    chk("R8 input pin change int", int_low, 1);
    pin_in = 8'hBC; repeat (6) @(negedge clk);
    chk("R9 int clears on return", int_low, 0);
    pin_in = 8'hB8; repeat (6) @(negedge clk);
    chk("R8 int again", int_low, 1);
    rd("R9 read input", 1, 8'hB7);
    repeat (6) @(negedge clk);
    chk("R9 int cleared by read", int_low, 0);

    wr("R10 write input reg", 8'h00, 1, 8'h00, 0);
    rd("R10 input unchanged", 1, 8'hB7);
    wr("R11 burst", 8'h02, 2, 8'h11, 8'h22);
    rd("R11 last byte kept", 1, 8'h22);
    wr("R11 ptr out", 8'h01, 0, 0, 0);
    rd("R11 out untouched", 1, 8'hA5);

    i_start(); send_byte({ADR, 1'b0}, a); send_byte(8'h03, a);
    for (int i = 0; i < 4; i++) begin
      sda_mlow = 1; hp(); scl_m = 1; hp(); scl_m = 0; repeat (2) @(negedge clk);
    end
    rst_n = 0; repeat (3) @(negedge clk);
    sda_mlow = 0; scl_m = 1; repeat (3) @(negedge clk);
    rst_n = 1; repeat (10) @(negedge clk);
    chk("R12 pin_oe after abort", pin_oe, 8'h00);
    chk("R12 sda released", sda_oe, 0);
    chk("R12 int low", int_low, 0);
    rd("R12 ptr back to input", 1, 8'hB8);
    wr("R12", 8'h03, 0, 0, 0); rd("R12 cfg default", 1, 8'hFF);
    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule